// File: doc/BRIEF.md
# Decoder-Controlled Ripple ALU

This block is a small combinational arithmetic logic unit. It takes two operands, a two-bit function code and a carry-in, and returns a result word and a carry-out. It is built from one bit-slice that is repeated across the word. Each slice has its own AND gate, its own OR gate and one full adder. An XOR gate in each slice can flip the bit of operand A before it reaches the adder.

The function code is decoded into four one-hot enables. Each enable gates one unit's bit onto the output. The subtract enable also drives the XOR inverters and forces the carry into the lowest slice to 1. The adder therefore computes B plus the two's complement of A, which is B minus A. The carry then ripples from the lowest slice to the highest. The block has no clock and no state, so its outputs follow its inputs directly.

Top module: `slice_alu`

## Requirements
- R1: With func = 0, result equals op_a AND op_b bit by bit, and carry_out is 0.
- R2: With func = 1, result equals op_a OR op_b bit by bit, and carry_out is 0.
- R3: With func = 2, result equals op_b minus op_a, taken modulo 2^W.
- R4: With func = 2, carry_out is 1 exactly when op_b is greater than or equal to op_a, which means no borrow occurred.
- R5: With func = 3, the value {carry_out, result} equals op_a + op_b + carry_in.
- R6: For func values 0, 1 and 2, carry_in has no effect on result or on carry_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (4) | Operand A. It is inverted when subtracting. |
| op_b | input | W (4) | Operand B |
| func | input | 2 | Function code: 0 = AND, 1 = OR, 2 = B - A, 3 = A + B |
| carry_in | input | 1 | Carry into the lowest slice. It is used only when func = 3. |
| result | output | W (4) | Result word |
| carry_out | output | 1 | Carry from the highest slice for arithmetic codes, otherwise 0 |

## Verification
The checks are immediate assertions that are evaluated whenever the inputs change. They assume that every input bit is a known 0 or 1, so they stay quiet while any input is still X at time zero. The stimulus drives only defined values. It walks every operand pair for every function code under both carry-in values, and it changes the inputs on one clock edge and samples the outputs on the opposite edge, after they have settled.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   func,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);

  logic [3:0] en;
  logic       arith;
  logic [W:0] chain;

  always_comb begin
    en = 4'b0000;
    en[func] = 1'b1;
  end

  assign arith    = en[2] | en[3];
  assign chain[0] = en[2] | (en[3] & carry_in);

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic ax, s_and, s_or, s_sum;
    assign ax           = op_a[i] ^ en[2];
    assign s_and        = op_a[i] & op_b[i];
    assign s_or         = op_a[i] | op_b[i];
    assign s_sum        = ax ^ op_b[i] ^ chain[i];
    assign chain[i+1]   = (ax & op_b[i]) | (chain[i] & (ax ^ op_b[i]));
    assign result[i]    = (en[0] & s_and) | (en[1] & s_or) | (arith & s_sum);
  end

  assign carry_out = arith & chain[W];

endmodule

module slice_alu_props #(
  parameter int W = 4
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [1:0]   fn,
  input logic         ci,
  input logic [W-1:0] res,
  input logic         co
);

  logic [W:0] add_ref;
  logic [W-1:0] diff_ref;

  always_comb begin
    add_ref  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    diff_ref = b - a;
    if (!$isunknown({a, b, fn, ci, res, co})) begin
      // R1
      and_fn_chk: assert (fn != 2'd0 || (res == (a & b) && !co));
      // R2
      or_fn_chk: assert (fn != 2'd1 || (res == (a | b) && !co));
      // R3
      sub_value_chk: assert (fn != 2'd2 || res == diff_ref);
      // R4
      sub_borrow_chk: assert (fn != 2'd2 || co == (b >= a));
      // R5
      add_value_chk: assert (fn != 2'd3 || {co, res} == add_ref);
    end
  end

endmodule

bind slice_alu slice_alu_props #(.W(W)) u_props (
  .a(op_a), .b(op_b), .fn(func), .ci(carry_in), .res(result), .co(carry_out)
);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0] func = 2'd0;
  logic carry_in = 1'b0;
  logic [W-1:0] result;
  logic carry_out;

  typedef struct packed {
    logic [1:0]   fn;
    logic         ci;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] r;
    logic         c;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_alu #(.W(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .func(func), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] fn, input logic ci);
    item_t it;
    int av, bv, sum;
    av = int'(a);
    bv = int'(b);
    it.fn = fn; it.ci = ci; it.a = a; it.b = b;
    case (fn)
      2'd0: begin it.r = a & b; it.c = 1'b0; end
      2'd1: begin it.r = a | b; it.c = 1'b0; end
      2'd2: begin it.r = W'(bv - av + (1 << W)); it.c = (bv >= av); end
      default: begin
        sum = av + bv + int'(ci);
        it.r = W'(sum); it.c = sum >= (1 << W);
      end
    endcase
    @(posedge clk);
    op_a <= a; op_b <= b; func <= fn; carry_in <= ci;
    q.push_back(it);
  endtask

  function automatic string tag_res(item_t it);
    if (it.ci && it.fn != 2'd3) return "R6";
    case (it.fn)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  function automatic string tag_co(item_t it);
    if (it.ci && it.fn != 2'd3) return "R6";
    case (it.fn)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (result !== it.r) begin
        bad++;
        $display("FAIL %s result fn=%0d a=%0d b=%0d ci=%0d actual=%0d expected=%0d",
                 tag_res(it), it.fn, it.a, it.b, it.ci, result, it.r);
      end
      total++;
      if (carry_out !== it.c) begin
        bad++;
        $display("FAIL %s carry fn=%0d a=%0d b=%0d ci=%0d actual=%0d expected=%0d",
                 tag_co(it), it.fn, it.a, it.b, it.ci, carry_out, it.c);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // R1: idle inputs give a zero result and no carry
    @(negedge clk);
    total++;
    if (result !== '0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle actual=%0d/%0d expected=0/0", result, carry_out);
    end
    // R3 R4 corners: equal operands, A above B, zero minus max
    drive(4'd5, 4'd5, 2'd2, 1'b0);
    drive(4'd9, 4'd2, 2'd2, 1'b0);
    drive(4'd15, 4'd0, 2'd2, 1'b0);
    // R5 corner: full overflow with carry-in
    drive(4'd15, 4'd15, 2'd3, 1'b1);
    // exhaustive sweep, covering R1 R2 R3 R4 R5 R6
    for (int f = 0; f < 4; f++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++)
            drive(W'(a), W'(b), 2'(f), 1'(ci));
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule